// File: doc/BRIEF.md
# Colour Lookup Register File

This block holds a colour lookup table behind a 32-bit register bus. It has 256 main entries and four overlay entries, each made of an 8-bit red, green and blue component. Software first writes an entry number to the index register. It then moves through the components of that entry with repeated data accesses. A single phase counter, shared by reads and writes, tracks which component comes next. After the blue component the index moves to the next entry, so a whole table can be loaded as one stream of writes.

Display logic reads the table through a separate lookup port. It presents a pixel index, or an overlay select together with an index whose low two bits choose the overlay entry, and gets back a 24-bit colour combinationally.

Top module: `clut_regfile`

## Requirements
- R1: After reset every component of every entry is 0x00, except main entry 255 and overlay entries 0 and 2, which hold 0xFF in all three components. The index and the phase both start at 0, and phase 0 means red.
- R2: An accepted write to offset 0x0 loads the index from bits 31:24 of the write data and sets the phase to red.
- R3: An accepted write to offset 0x4 stores bits 31:24 of the write data into one component of the main entry at the current index, in the order red, green, blue. The lookup port returns an entry as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: The access that handles the blue component increments the index modulo 256, so 255 wraps to 0, and returns the phase to red.
- R5: An accepted write to offset 0xC follows the same three-phase order but targets overlay entry (index & 3), and it advances the index exactly as in R4. Main entries are not changed.
- R6: During an accepted read at any offset, the read data carries the current main entry's component for the present phase in bits 31:24 and zero in bits 23:0. The read advances the same phase counter that writes use, including the index step after blue. When no accepted read is in progress, the read data is zero.
- R7: Writes to any offset other than 0x0, 0x4 and 0xC are ignored: entries, index and phase are all unchanged.
- R8: Only full-word accesses are accepted, meaning all four byte enables are 1. Any other access changes nothing, and a read of this kind returns zero.
- R9: The lookup port is combinational. With lk_overlay at 0 it selects main entry lk_index; with lk_overlay at 1 it selects overlay entry lk_index[1:0]. A component write is visible on the port after the clock edge that accepts it.
- R10: An index write in the middle of a sequence abandons that sequence. Components already written are kept, and the next data access starts again at red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data; the payload is in bits 31:24 |
| bus_rdata | output | 32 | Read data, combinational during the read cycle |
| lk_index | input | 8 | Pixel index for the lookup port |
| lk_overlay | input | 1 | Selects the overlay entries for the lookup |
| lk_rgb | output | 24 | Colour of the selected entry |

## Verification
The bench targets the seams of the shared phase counter. It interleaves reads and writes within one entry: a design that kept separate read and write counters would return red where green is due. It loads entry 255 and continues writing, so a design without the modulo wrap would drop that data or stall. It sends overlay writes and then sweeps the main table, which catches an overlay write leaking into main entry (index & 3) or failing to advance the index. It aborts sequences with an index write, writes to offset 0x8 and sends partial byte enables; a design that mishandled any of these would show a changed colour or a shifted phase on the next read.

// File: rtl/clut_pkg.sv
`timescale 1ns/1ps
package clut_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2,
        PH_BAD = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_SETIDX   = 3'd1,
        OP_DATA_MAIN = 3'd2,
        OP_DATA_OVL = 3'd3,
        OP_READ     = 3'd4
    } op_e;

endpackage

// File: rtl/clut_decode.sv
`timescale 1ns/1ps
module clut_decode #(
    parameter int ADDR_W   = 4,
    parameter int BE_W     = 4,
    parameter int OFS_IDX  = 0,
    parameter int OFS_MAIN = 4,
    parameter int OFS_OVL  = 12
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    output clut_pkg::op_e     op
);
    import clut_pkg::*;

    always_comb begin
        op = OP_NONE;
        if (bus_valid && (&bus_be)) begin
            if (!bus_write) begin
                op = OP_READ;
            end else if (bus_addr == ADDR_W'(OFS_IDX)) begin
                op = OP_SETIDX;
            end else if (bus_addr == ADDR_W'(OFS_MAIN)) begin
                op = OP_DATA_MAIN;
            end else if (bus_addr == ADDR_W'(OFS_OVL)) begin
                op = OP_DATA_OVL;
            end
        end
    end

endmodule

// File: rtl/clut_seq.sv
`timescale 1ns/1ps
module clut_seq #(
    parameter int IDX_W    = 8,
    parameter int OVL_W    = 2,
    parameter int COMP_W   = 8,
    parameter int NUM_MAIN = 2**IDX_W,
    parameter int ENTRY_W  = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  clut_pkg::op_e        op,
    input  logic [COMP_W-1:0]    wbyte,
    output logic [IDX_W-1:0]     cur_idx,
    output clut_pkg::phase_e     cur_ph,
    output logic                 wr_en,
    output logic [ENTRY_W-1:0]   wr_entry,
    output clut_pkg::phase_e     wr_comp
);
    import clut_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           ph;
    } seq_t;

    seq_t seq_d, seq_q;
    logic is_data, is_write;

    always_comb begin
        seq_d    = seq_q;
        is_data  = (op == OP_DATA_MAIN) || (op == OP_DATA_OVL) || (op == OP_READ);
        is_write = (op == OP_DATA_MAIN) || (op == OP_DATA_OVL);
        wr_en    = 1'b0;
        wr_comp  = seq_q.ph;
        if (op == OP_DATA_OVL) begin
            wr_entry = ENTRY_W'(NUM_MAIN) + ENTRY_W'(seq_q.idx[OVL_W-1:0]);
        end else begin
            wr_entry = ENTRY_W'(seq_q.idx);
        end

        if (op == OP_SETIDX) begin
            seq_d.idx = IDX_W'(wbyte);
            seq_d.ph  = PH_RED;
        end else if (is_data) begin
            unique case (seq_q.ph)
                PH_RED: begin
                    wr_en    = is_write;
                    seq_d.ph = PH_GRN;
                end
                PH_GRN: begin
                    wr_en    = is_write;
                    seq_d.ph = PH_BLU;
                end
                PH_BLU: begin
                    wr_en     = is_write;
                    seq_d.idx = seq_q.idx + 1'b1;
                    seq_d.ph  = PH_RED;
                end
                default: begin
                    seq_d.ph = PH_RED;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{idx: '0, ph: PH_RED};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cur_idx = seq_q.idx;
    assign cur_ph  = seq_q.ph;

endmodule

// File: rtl/clut_store.sv
`timescale 1ns/1ps
module clut_store #(
    parameter int COMP_W   = 8,
    parameter int NUM_MAIN = 256,
    parameter int NUM_OVL  = 4,
    parameter int ENTRY_W  = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ENTRY_W-1:0]    wr_entry,
    input  clut_pkg::phase_e      wr_comp,
    input  logic [COMP_W-1:0]     wr_byte,
    input  logic [ENTRY_W-1:0]    rd_entry,
    input  clut_pkg::phase_e      rd_comp,
    output logic [COMP_W-1:0]     rd_byte,
    input  logic [ENTRY_W-1:0]    lk_entry,
    output logic [3*COMP_W-1:0]   lk_rgb
);
    import clut_pkg::*;

    localparam int NUM_ENT = NUM_MAIN + NUM_OVL;
    localparam int RGB_W   = 3 * COMP_W;

    logic [RGB_W-1:0] pal [NUM_ENT];

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        localparam bit WHITE = (e == NUM_MAIN - 1) || (e == NUM_MAIN) || (e == NUM_MAIN + 2);
        localparam logic [RGB_W-1:0] RST_VAL = WHITE ? {RGB_W{1'b1}} : {RGB_W{1'b0}};

        logic [RGB_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_entry == ENTRY_W'(e))) begin
                unique case (wr_comp)
                    PH_RED:  ent_d[3*COMP_W-1:2*COMP_W] = wr_byte;
                    PH_GRN:  ent_d[2*COMP_W-1:COMP_W]   = wr_byte;
                    PH_BLU:  ent_d[COMP_W-1:0]          = wr_byte;
                    default: ent_d = ent_q;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= RST_VAL;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign pal[e] = ent_q;
    end

    logic [RGB_W-1:0] rd_rgb;

    always_comb begin
        rd_rgb = pal[rd_entry];
        unique case (rd_comp)
            PH_RED:  rd_byte = rd_rgb[3*COMP_W-1:2*COMP_W];
            PH_GRN:  rd_byte = rd_rgb[2*COMP_W-1:COMP_W];
            PH_BLU:  rd_byte = rd_rgb[COMP_W-1:0];
            default: rd_byte = '0;
        endcase
    end

    assign lk_rgb = pal[lk_entry];

endmodule

// File: rtl/clut_regfile.sv
`timescale 1ns/1ps
module clut_regfile #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int COMP_W   = 8,
    parameter int IDX_W    = 8,
    parameter int OVL_W    = 2,
    parameter int OFS_IDX  = 0,
    parameter int OFS_MAIN = 4,
    parameter int OFS_OVL  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W/8-1:0]  bus_be,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [IDX_W-1:0]     lk_index,
    input  logic                 lk_overlay,
    output logic [3*COMP_W-1:0]  lk_rgb
);
    import clut_pkg::*;

    localparam int BE_W     = DATA_W / 8;
    localparam int NUM_MAIN = 2**IDX_W;
    localparam int NUM_OVL  = 2**OVL_W;
    localparam int ENTRY_W  = $clog2(NUM_MAIN + NUM_OVL);

    op_e                 op;
    logic [COMP_W-1:0]   wbyte;
    logic [IDX_W-1:0]    cur_idx;
    phase_e              cur_ph;
    logic                wr_en;
    logic [ENTRY_W-1:0]  wr_entry;
    phase_e              wr_comp;
    logic [COMP_W-1:0]   rd_byte;
    logic [ENTRY_W-1:0]  lk_entry;
    logic                unused_low;

    assign wbyte      = bus_wdata[DATA_W-1 -: COMP_W];
    assign unused_low = ^bus_wdata[DATA_W-COMP_W-1:0];

    clut_decode #(
        .ADDR_W(ADDR_W), .BE_W(BE_W),
        .OFS_IDX(OFS_IDX), .OFS_MAIN(OFS_MAIN), .OFS_OVL(OFS_OVL)
    ) decode_i (
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .op       (op)
    );

    clut_seq #(
        .IDX_W(IDX_W), .OVL_W(OVL_W), .COMP_W(COMP_W),
        .NUM_MAIN(NUM_MAIN), .ENTRY_W(ENTRY_W)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wbyte   (wbyte),
        .cur_idx (cur_idx),
        .cur_ph  (cur_ph),
        .wr_en   (wr_en),
        .wr_entry(wr_entry),
        .wr_comp (wr_comp)
    );

    always_comb begin
        if (lk_overlay) begin
            lk_entry = ENTRY_W'(NUM_MAIN) + ENTRY_W'(lk_index[OVL_W-1:0]);
        end else begin
            lk_entry = ENTRY_W'(lk_index);
        end
    end

    clut_store #(
        .COMP_W(COMP_W), .NUM_MAIN(NUM_MAIN), .NUM_OVL(NUM_OVL), .ENTRY_W(ENTRY_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_entry(wr_entry),
        .wr_comp (wr_comp),
        .wr_byte (wbyte),
        .rd_entry(ENTRY_W'(cur_idx)),
        .rd_comp (cur_ph),
        .rd_byte (rd_byte),
        .lk_entry(lk_entry),
        .lk_rgb  (lk_rgb)
    );

    always_comb begin
        bus_rdata = '0;
        if ((op == OP_READ) && (cur_ph != PH_BAD)) begin
            bus_rdata[DATA_W-1 -: COMP_W] = rd_byte;
        end
    end

endmodule

// File: rtl/clut_regfile_chk.sv
`timescale 1ns/1ps
module clut_regfile_chk #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int COMP_W   = 8,
    parameter int IDX_W    = 8,
    parameter int OFS_IDX  = 0,
    parameter int OFS_MAIN = 4,
    parameter int OFS_OVL  = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W/8-1:0]  bus_be,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [IDX_W-1:0]     lk_index,
    input logic                 lk_overlay,
    input logic [3*COMP_W-1:0]  lk_rgb,
    input logic [IDX_W-1:0]     cur_idx,
    input logic [1:0]           cur_ph
);
    logic acc, data_acc, known_ofs;
    assign acc       = bus_valid && (&bus_be);
    assign known_ofs = (bus_addr == ADDR_W'(OFS_IDX)) || (bus_addr == ADDR_W'(OFS_MAIN))
                    || (bus_addr == ADDR_W'(OFS_OVL));
    assign data_acc  = acc && (!bus_write || (bus_addr == ADDR_W'(OFS_MAIN))
                    || (bus_addr == ADDR_W'(OFS_OVL)));

    p_rdata_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-COMP_W-1:0] == '0);

    p_rdata_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && !bus_write) |-> bus_rdata == '0);

    p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ph != 2'd3);

    p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_write && bus_addr == ADDR_W'(OFS_IDX)) |=>
            (cur_idx == IDX_W'($past(bus_wdata[DATA_W-1 -: COMP_W])) && cur_ph == 2'd0));

    p_blue_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && cur_ph == 2'd2) |=>
            (cur_ph == 2'd0 && cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

    p_ignored_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_write && !known_ofs) |=> ($stable(cur_idx) && $stable(cur_ph)));

    p_partial_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !(&bus_be)) |=> ($stable(cur_idx) && $stable(cur_ph)));

    p_lookup_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_valid) && $stable(lk_index) && $stable(lk_overlay))
            |-> $stable(lk_rgb));

endmodule

bind clut_regfile clut_regfile_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMP_W(COMP_W), .IDX_W(IDX_W),
    .OFS_IDX(OFS_IDX), .OFS_MAIN(OFS_MAIN), .OFS_OVL(OFS_OVL)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lk_index  (lk_index),
    .lk_overlay(lk_overlay),
    .lk_rgb    (lk_rgb),
    .cur_idx   (cur_idx),
    .cur_ph    (cur_ph)
);

// File: tb/clut_regfile_tb_top.sv
`timescale 1ns/1ps
module clut_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lk_index = '0;
    logic        lk_overlay = 1'b0;
    logic [23:0] lk_rgb;

    always #10 clk = ~clk;

    clut_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lk_index(lk_index), .lk_overlay(lk_overlay), .lk_rgb(lk_rgb)
    );

    int n_vec  = 0;
    int n_fail = 0;

    int m_r[260];
    int m_g[260];
    int m_b[260];
    int m_idx = 0;
    int m_ph  = 0;

    int li_g = 0;
    bit lo_g = 1'b0;

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int ent_of(input int li, input bit lo);
        return lo ? (256 + (li & 3)) : li;
    endfunction

    function automatic logic [23:0] model_rgb(input int e);
        return {m_r[e][7:0], m_g[e][7:0], m_b[e][7:0]};
    endfunction

    task automatic model_reset();
        for (int e = 0; e < 260; e++) begin
            m_r[e] = 0; m_g[e] = 0; m_b[e] = 0;
        end
        m_r[255] = 255; m_g[255] = 255; m_b[255] = 255;
        m_r[256] = 255; m_g[256] = 255; m_b[256] = 255;
        m_r[258] = 255; m_g[258] = 255; m_b[258] = 255;
        m_idx = 0;
        m_ph  = 0;
    endtask

    // One bus cycle: drive after the falling edge, compare before the rising edge,
    // then advance the model to the state after that edge.
    task automatic step(input bit v, input bit w, input int a, input logic [31:0] d,
                        input logic [3:0] be, input string req);
        logic [31:0] exp_rd;
        int tgt;
        bus_valid  = v;
        bus_write  = w;
        bus_addr   = 4'(a);
        bus_wdata  = d;
        bus_be     = be;
        lk_index   = 8'(li_g);
        lk_overlay = lo_g;
        #5;
        exp_rd = 32'h0;
        if (v && be == 4'hF && !w) begin
            case (m_ph)
                0: exp_rd = {m_r[m_idx][7:0], 24'h0};
                1: exp_rd = {m_g[m_idx][7:0], 24'h0};
                default: exp_rd = {m_b[m_idx][7:0], 24'h0};
            endcase
        end
        check(req, "rdata", bus_rdata, exp_rd);
        check(req, "lookup", {8'h0, lk_rgb}, {8'h0, model_rgb(ent_of(li_g, lo_g))});
        if (v && be == 4'hF) begin
            if (w && a == 0) begin
                m_idx = int'(d[31:24]);
                m_ph  = 0;
            end else if (!w || a == 4 || a == 12) begin
                tgt = (w && a == 12) ? 256 + (m_idx & 3) : m_idx;
                if (w) begin
                    case (m_ph)
                        0: m_r[tgt] = int'(d[31:24]);
                        1: m_g[tgt] = int'(d[31:24]);
                        default: m_b[tgt] = int'(d[31:24]);
                    endcase
                end
                if (m_ph == 2) begin
                    m_ph  = 0;
                    m_idx = (m_idx + 1) % 256;
                end else begin
                    m_ph = m_ph + 1;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int b, input string req);
        step(1'b1, 1'b1, a, {8'(b), 24'h5A5A5A}, 4'hF, req);
    endtask

    task automatic rd(input int a, input string req);
        step(1'b1, 1'b0, a, 32'h0, 4'hF, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 0, 32'h0, 4'h0, req);
    endtask

    task automatic sweep(input string req);
        for (int e = 0; e < 260; e++) begin
            li_g = (e < 256) ? e : (e - 256);
            lo_g = (e >= 256);
            idle(req);
        end
        li_g = 0;
        lo_g = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents, then index/phase at 0 seen by reads of entry 0
        sweep("R1");
        rd(4, "R1"); rd(4, "R1"); rd(4, "R1");

        // R2, R3: load index 10 and write one entry
        wr(0, 10, "R2");
        wr(4, 8'h12, "R3"); wr(4, 8'h34, "R3"); wr(4, 8'h56, "R3");
        li_g = 10; idle("R3");
        li_g = 11; wr(4, 8'hA1, "R2"); li_g = 11; idle("R3");

        // R4: entry 255 then wrap to entry 0
        wr(0, 255, "R4");
        li_g = 255;
        wr(4, 8'h01, "R4"); wr(4, 8'h02, "R4"); wr(4, 8'h03, "R4");
        li_g = 0;
        wr(4, 8'h77, "R4"); idle("R4");

        // R5: overlay entries, index 6 -> overlay 2, index steps to 7
        wr(0, 6, "R5");
        lo_g = 1'b1; li_g = 2;
        wr(12, 8'h0F, "R5"); wr(12, 8'h1E, "R5"); wr(12, 8'h2D, "R5");
        idle("R5");
        lo_g = 1'b0; li_g = 7;
        wr(4, 8'hC7, "R5"); idle("R5");
        wr(0, 3, "R5");
        wr(12, 8'h90, "R5"); wr(12, 8'h91, "R5"); wr(12, 8'h92, "R5");
        sweep("R5");

        // R6: reads step phase, wrap index; shared with writes
        wr(0, 254, "R6");
        for (int k = 0; k < 9; k++) rd(8, "R6");
        wr(0, 10, "R6");
        wr(4, 8'hEE, "R6");
        rd(4, "R6"); rd(0, "R6");
        wr(4, 8'hDD, "R6");
        li_g = 11; idle("R6");

        // R7: unknown offsets are ignored
        wr(0, 20, "R7");
        wr(8, 8'hFF, "R7"); wr(2, 8'hFF, "R7"); wr(15, 8'hFF, "R7");
        rd(4, "R7");
        li_g = 20; idle("R7");

        // R8: partial byte enables change nothing and read zero
        wr(0, 30, "R8");
        step(1'b1, 1'b1, 4, 32'hAB000000, 4'h7, "R8");
        step(1'b1, 1'b1, 0, 32'h05000000, 4'h8, "R8");
        step(1'b1, 1'b0, 4, 32'h0, 4'hE, "R8");
        rd(4, "R8");
        li_g = 30; idle("R8");

        // R10: index write mid-sequence restarts at red
        wr(0, 40, "R10");
        wr(4, 8'h11, "R10"); wr(4, 8'h22, "R10");
        wr(0, 40, "R10");
        wr(4, 8'h33, "R10");
        li_g = 40; idle("R10");
        rd(4, "R10");

        // R9 and R3: pseudo-random mixed traffic with moving lookup
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            int sel, a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel  = int'(lfsr[2:0]);
            li_g = int'(lfsr[15:8]);
            lo_g = lfsr[7] & lfsr[6];
            case (sel)
                0: a = 0;
                1, 2, 3: a = 4;
                4: a = 12;
                5: a = 8;
                default: a = 4;
            endcase
            if (sel == 6) rd(a, "R9");
            else if (sel == 7 && lfsr[5]) idle("R9");
            else wr(a, int'(lfsr[11:4]), "R3");
        end
        sweep("R3");

        summary();
        $finish;
    end

endmodule